// File: doc/BRIEF.md
# SPI Peripheral Local Power-Down Clock Controller

This block decides which clock domains of a serial peripheral may run. It drives three clock-enable outputs: one for the core logic (the shift engine and its state machines), one for the register file and one for the buffer RAM. Actual clock-gating cells sit outside it. It holds a power-down bit, bit 8 of the peripheral's first global control register. Software sets that bit to enter local power-down and clears it to leave.

While the block is powered down, the core enable stays off. A bus access still wakes the enable of the domain it targets, register file or buffer RAM. That enable rises in the cycle the request arrives and stays on through the acknowledge cycle, then drops. Because the control register is reached over this same path, software can always clear the power-down bit again.

A separate system low-power input overrides everything. It forces all three enables off and holds any bus access unacknowledged until the input falls. A status output reports whether either kind of low-power state is in force.

Top module: `spi_pm_clkctl`

## Requirements
- R1: After reset the power-down bit is 0, `core_clk_en`, `reg_clk_en` and `ram_clk_en` are 1 (with `sys_lp_req` low), `bus_ack` is 0 and `lp_status` is 0.
- R2: A register-space write (`bus_sel_ram`=0) to address `CTRL_ADDR` (0) with bit 8 of `bus_wdata` set enters power-down. From the cycle after its acknowledge, all three enables are 0 while no access is in progress.
- R3: During power-down, a register-space access drives `reg_clk_en` to 1 from its request cycle through its acknowledge cycle, while `ram_clk_en` and `core_clk_en` stay 0.
- R4: During power-down, a buffer-RAM access (`bus_sel_ram`=1) drives `ram_clk_en` to 1 from its request cycle through its acknowledge cycle, while `reg_clk_en` and `core_clk_en` stay 0.
- R5: A register write of 0 to bit 8 of `CTRL_ADDR` while powered down takes effect. From the cycle after its acknowledge, all three enables are 1 again.
- R6: `bus_ack` is a one-cycle pulse, WAIT_CYC+1 cycles after the cycle in which the request is accepted (the request is held high until acknowledged).
- R7: While `sys_lp_req` is 1, all three enables are 0, no request is accepted and no acknowledge is given. A held or in-flight access resumes where it stopped once the input falls.
- R8: `lp_status` is 1 exactly when the power-down bit or `sys_lp_req` is 1.
- R9: A register-space read of `CTRL_ADDR` returns the power-down bit at bit 8 and 0 in every other bit of `bus_rdata` during the acknowledge cycle. Written values of the other bits are not kept.
- R10: Writes to other register addresses or to buffer RAM leave the power-down bit unchanged, whatever data they carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_lp_req | input | 1 | System-wide low-power request |
| bus_req | input | 1 | Access request, held until acknowledged |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_sel_ram | input | 1 | 1 targets buffer RAM, 0 targets registers |
| bus_addr | input | ADDR_W | Access address |
| bus_wdata | input | DATA_W | Write data |
| bus_ack | output | 1 | One-cycle access acknowledge |
| bus_rdata | output | DATA_W | Control-register read data, valid with acknowledge |
| core_clk_en | output | 1 | Enable for the core logic clock |
| reg_clk_en | output | 1 | Enable for the register-file clock |
| ram_clk_en | output | 1 | Enable for the buffer-RAM clock |
| lp_status | output | 1 | Any low-power state active |

## Verification
The bench follows the enables cycle by cycle across accesses made while powered down. A design that dropped the register enable one cycle before the acknowledge, or kept it one cycle after, fails there, and so does one that woke the wrong domain for a RAM access. It clears the power-down bit through the register path while powered down, which a design gating its own control register with the stopped clock could never leave. It writes ones to neighbouring bits, to other addresses and to RAM to catch a decoder that touches the power-down bit too loosely. It also raises the system low-power input in the middle of an access, where a design that kept counting or acknowledged through the stall shows an early acknowledge.

// File: rtl/spi_pm_pkg.sv
package spi_pm_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_WAIT = 2'd1,
        ACC_ACK  = 2'd2
    } acc_state_e;

    typedef enum logic {
        TGT_REG = 1'b0,
        TGT_RAM = 1'b1
    } acc_tgt_e;

    // Decoded access command, captured when the request is accepted.
    typedef struct packed {
        acc_tgt_e tgt;
        logic     we;
        logic     hit_ctrl;
        logic     pd_val;
    } acc_cmd_t;

    typedef struct packed {
        logic core;
        logic regs;
        logic ram;
    } clk_en_t;

    // Enable policy: the system request kills every clock; local power-down
    // kills the core and leaves only the domain of a live access running.
    function automatic clk_en_t pm_enables(input logic sys_lp, input logic pd,
                                           input logic live, input acc_tgt_e tgt);
        clk_en_t e;
        e.core = !sys_lp && !pd;
        e.regs = !sys_lp && (!pd || (live && tgt == TGT_REG));
        e.ram  = !sys_lp && (!pd || (live && tgt == TGT_RAM));
        return e;
    endfunction

endpackage

// File: rtl/spi_pm_access_seq.sv
module spi_pm_access_seq
    import spi_pm_pkg::*;
#(
    parameter int unsigned WAIT_CYC = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sys_lp,
    input  logic     req,
    input  acc_cmd_t cmd_in,
    output logic     ack,
    output logic     live,
    output acc_cmd_t cmd_cur,
    output logic     commit,
    output logic     rd_ctrl
);
    localparam int unsigned CNT_W = $clog2(WAIT_CYC + 2);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYC);

    acc_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    acc_cmd_t       cmd_q;
    acc_state_e     first_state;

    generate
        if (WAIT_CYC == 0) begin : g_no_wait
            assign first_state = ACC_ACK;
        end else begin : g_wait
            assign first_state = ACC_WAIT;
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!sys_lp) begin
            unique case (state_q)
                ACC_IDLE: if (req) begin
                    state_d = first_state;
                    cnt_d   = CNT_W'(1);
                end
                ACC_WAIT: begin
                    if (cnt_q == CNT_LAST) state_d = ACC_ACK;
                    else                   cnt_d   = cnt_q + CNT_W'(1);
                end
                ACC_ACK:  state_d = ACC_IDLE;
                default:  state_d = ACC_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ACC_IDLE;
            cnt_q   <= '0;
            cmd_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (state_q == ACC_IDLE && req && !sys_lp) cmd_q <= cmd_in;
        end
    end

    assign live    = (state_q == ACC_IDLE) ? req : 1'b1;
    assign cmd_cur = (state_q == ACC_IDLE) ? cmd_in : cmd_q;
    assign ack     = (state_q == ACC_ACK) && !sys_lp;
    assign commit  = ack && cmd_q.we && cmd_q.hit_ctrl;
    assign rd_ctrl = ack && !cmd_q.we && cmd_q.hit_ctrl;

endmodule

// File: rtl/spi_pm_ctrl_reg.sv
module spi_pm_ctrl_reg #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PD_BIT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic              pd_val,
    input  logic              rd_sel,
    output logic              pd,
    output logic [DATA_W-1:0] rdata
);
    logic pd_q;

    // Lives in the always-running domain so it can always be rewritten.
    always_ff @(posedge clk) begin
        if (rst)         pd_q <= 1'b0;
        else if (commit) pd_q <= pd_val;
    end

    assign pd    = pd_q;
    assign rdata = rd_sel ? (DATA_W'(pd_q) << PD_BIT) : '0;

endmodule

// File: rtl/spi_pm_clk_en.sv
module spi_pm_clk_en
    import spi_pm_pkg::*;
(
    input  logic     sys_lp,
    input  logic     pd,
    input  logic     live,
    input  acc_tgt_e tgt,
    output clk_en_t  en,
    output logic     status
);
    assign en     = pm_enables(sys_lp, pd, live, tgt);
    assign status = pd || sys_lp;
endmodule

// File: rtl/spi_pm_clkctl.sv
module spi_pm_clkctl
    import spi_pm_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned PD_BIT   = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
    parameter int unsigned WAIT_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sys_lp_req,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic              bus_sel_ram,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              core_clk_en,
    output logic              reg_clk_en,
    output logic              ram_clk_en,
    output logic              lp_status
);
    acc_cmd_t cmd_in, cmd_cur;
    logic     live, commit, rd_ctrl, pd;
    clk_en_t  en;
    logic     unused_wdata_bits;

    assign cmd_in.tgt      = bus_sel_ram ? TGT_RAM : TGT_REG;
    assign cmd_in.we       = bus_we;
    assign cmd_in.hit_ctrl = !bus_sel_ram && (bus_addr == CTRL_ADDR);
    assign cmd_in.pd_val   = bus_wdata[PD_BIT];
    assign unused_wdata_bits = ^{bus_wdata[DATA_W-1:PD_BIT+1], bus_wdata[PD_BIT-1:0]};

    spi_pm_access_seq #(.WAIT_CYC(WAIT_CYC)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .sys_lp  (sys_lp_req),
        .req     (bus_req),
        .cmd_in  (cmd_in),
        .ack     (bus_ack),
        .live    (live),
        .cmd_cur (cmd_cur),
        .commit  (commit),
        .rd_ctrl (rd_ctrl)
    );

    spi_pm_ctrl_reg #(.DATA_W(DATA_W), .PD_BIT(PD_BIT)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .pd_val (cmd_cur.pd_val),
        .rd_sel (rd_ctrl),
        .pd     (pd),
        .rdata  (bus_rdata)
    );

    spi_pm_clk_en u_en (
        .sys_lp (sys_lp_req),
        .pd     (pd),
        .live   (live),
        .tgt    (cmd_cur.tgt),
        .en     (en),
        .status (lp_status)
    );

    assign core_clk_en = en.core;
    assign reg_clk_en  = en.regs;
    assign ram_clk_en  = en.ram;

endmodule

// File: rtl/spi_pm_clkctl_chk.sv
module spi_pm_clkctl_chk (
    input logic clk,
    input logic rst,
    input logic sys_lp_req,
    input logic bus_req,
    input logic bus_ack,
    input logic core_clk_en,
    input logic reg_clk_en,
    input logic ram_clk_en,
    input logic lp_status
);
    a_r7_all_clocks_off: assert property (@(posedge clk) disable iff (rst)
        sys_lp_req |-> !(core_clk_en || reg_clk_en || ram_clk_en));

    a_r7_no_ack_in_sys_lp: assert property (@(posedge clk) disable iff (rst)
        sys_lp_req |-> !bus_ack);

    a_r8_status_vs_core: assert property (@(posedge clk) disable iff (rst)
        !sys_lp_req |-> (lp_status != core_clk_en));

    a_r6_ack_single_pulse: assert property (@(posedge clk) disable iff (rst)
        bus_ack |=> !bus_ack);

    a_r3_ack_domain_awake: assert property (@(posedge clk) disable iff (rst)
        bus_ack |-> (reg_clk_en || ram_clk_en));

    a_r4_one_domain_in_pd: assert property (@(posedge clk) disable iff (rst)
        (lp_status && !sys_lp_req) |-> !(reg_clk_en && ram_clk_en));

    a_r2_idle_all_off: assert property (@(posedge clk) disable iff (rst)
        (lp_status && !bus_req && !bus_ack) |-> !(reg_clk_en || ram_clk_en));
endmodule

bind spi_pm_clkctl spi_pm_clkctl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .sys_lp_req  (sys_lp_req),
    .bus_req     (bus_req),
    .bus_ack     (bus_ack),
    .core_clk_en (core_clk_en),
    .reg_clk_en  (reg_clk_en),
    .ram_clk_en  (ram_clk_en),
    .lp_status   (lp_status)
);

// File: tb/spi_pm_clkctl_test.sv
module spi_pm_clkctl_test;
    localparam int W = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sys_lp_req = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_sel_ram = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack;
    logic [31:0] bus_rdata;
    logic        core_clk_en, reg_clk_en, ram_clk_en, lp_status;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    logic pd_m = 1'b0;

    always #4 clk = ~clk;

    spi_pm_clkctl #(.WAIT_CYC(W)) uut (
        .clk(clk), .rst(rst), .sys_lp_req(sys_lp_req),
        .bus_req(bus_req), .bus_we(bus_we), .bus_sel_ram(bus_sel_ram),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .core_clk_en(core_clk_en), .reg_clk_en(reg_clk_en),
        .ram_clk_en(ram_clk_en), .lp_status(lp_status)
    );

    typedef struct packed {
        logic        ram;
        logic        we;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [31:0] rd_exp;
        logic        pd_exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 8'h00, 32'h0000_0000, 32'h0000_0000, 1'b0},
        '{1'b0, 1'b1, 8'h00, 32'h0000_0100, 32'h0000_0000, 1'b1},
        '{1'b0, 1'b0, 8'h00, 32'h0000_0000, 32'h0000_0100, 1'b1},
        '{1'b1, 1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1},
        '{1'b1, 1'b0, 8'h00, 32'h0000_0000, 32'h0000_0000, 1'b1},
        '{1'b0, 1'b1, 8'h04, 32'h0000_0000, 32'h0000_0000, 1'b1},
        '{1'b0, 1'b1, 8'h00, 32'hFFFF_FEFF, 32'h0000_0000, 1'b0},
        '{1'b0, 1'b0, 8'h00, 32'h0000_0000, 32'h0000_0000, 1'b0},
        '{1'b0, 1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1},
        '{1'b0, 1'b0, 8'h00, 32'h0000_0000, 32'h0000_0100, 1'b1},
        '{1'b0, 1'b1, 8'h00, 32'h0000_0000, 32'h0000_0000, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic chk_en(input logic ram, input string ctx);
        logic [2:0] got, exp;
        got = {core_clk_en, reg_clk_en, ram_clk_en};
        if (pd_m) exp = {1'b0, !ram, ram};
        else      exp = 3'b111;
        if (!pd_m)    chk(got == exp, {"R5 enables awake ", ctx}, 32'(got), 32'(exp));
        else if (ram) chk(got == exp, {"R4 ram wake ", ctx}, 32'(got), 32'(exp));
        else          chk(got == exp, {"R3 reg wake ", ctx}, 32'(got), 32'(exp));
    endtask

    task automatic run_vec(input vec_t v);
        logic pd_before;
        pd_before = pd_m;
        @(negedge clk);
        bus_req = 1'b1; bus_we = v.we; bus_sel_ram = v.ram;
        bus_addr = v.addr; bus_wdata = v.wdata;
        for (int c = 0; c <= W + 1; c++) begin
            if (c > 0) @(negedge clk);
            #1;
            chk(bus_ack == (c == W + 1), "R6 ack timing", 32'(bus_ack), 32'(c == W + 1));
            chk_en(v.ram, "during access");
            if (c == W + 1 && !v.we)
                chk(bus_rdata == v.rd_exp, "R9 read data", bus_rdata, v.rd_exp);
        end
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        #1;
        pd_m = v.pd_exp;
        chk(bus_ack == 1'b0, "R6 ack one cycle", 32'(bus_ack), 32'h0);
        if (v.we && !v.ram && v.addr == 8'h00) begin
            if (pd_before && !v.pd_exp)
                chk(core_clk_en && reg_clk_en && ram_clk_en, "R5 exit power-down",
                    32'({core_clk_en, reg_clk_en, ram_clk_en}), 32'h7);
            else if (v.pd_exp)
                chk(!core_clk_en && !reg_clk_en && !ram_clk_en, "R2 enter power-down",
                    32'({core_clk_en, reg_clk_en, ram_clk_en}), 32'h0);
        end else begin
            chk(lp_status == pd_before, "R10 pd unchanged", 32'(lp_status), 32'(pd_before));
        end
        chk(lp_status == pd_m, "R8 status after access", 32'(lp_status), 32'(pd_m));
    endtask

    initial begin : watchdog
        while (cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        #1;
        chk(core_clk_en && reg_clk_en && ram_clk_en, "R1 enables in reset",
            32'({core_clk_en, reg_clk_en, ram_clk_en}), 32'h7);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(bus_ack == 1'b0, "R1 ack after reset", 32'(bus_ack), 32'h0);
        chk(lp_status == 1'b0, "R1 status after reset", 32'(lp_status), 32'h0);
        chk(bus_rdata == 32'h0, "R1 rdata idle", bus_rdata, 32'h0);

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R7/R8: system low-power with local bit clear
        @(negedge clk);
        sys_lp_req = 1'b1;
        #1;
        chk(!core_clk_en && !reg_clk_en && !ram_clk_en, "R7 sys lp all off",
            32'({core_clk_en, reg_clk_en, ram_clk_en}), 32'h0);
        chk(lp_status == 1'b1, "R8 status from sys lp", 32'(lp_status), 32'h1);
        // R7: request held during sys lp is not accepted
        bus_req = 1'b1; bus_we = 1'b0; bus_sel_ram = 1'b0; bus_addr = 8'h00;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk); #1;
            chk(bus_ack == 1'b0, "R7 no ack in sys lp", 32'(bus_ack), 32'h0);
            chk(!reg_clk_en, "R7 reg off in sys lp", 32'(reg_clk_en), 32'h0);
        end
        @(negedge clk);
        sys_lp_req = 1'b0;
        for (int c = 0; c <= W + 1; c++) begin
            if (c > 0) @(negedge clk);
            #1;
            chk(bus_ack == (c == W + 1), "R7 resumed ack", 32'(bus_ack), 32'(c == W + 1));
        end
        @(negedge clk);
        bus_req = 1'b0;

        // Enter power-down again, then stall an access mid-flight with sys lp
        run_vec('{1'b0, 1'b1, 8'h00, 32'h0000_0100, 32'h0, 1'b1});
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_sel_ram = 1'b0; bus_addr = 8'h00;
        for (int c = 0; c <= W + 4; c++) begin
            if (c > 0) @(negedge clk);
            sys_lp_req = (c >= 1 && c <= 3);
            #1;
            chk(bus_ack == (c == W + 4), "R7 stalled ack", 32'(bus_ack), 32'(c == W + 4));
            if (sys_lp_req)
                chk(!reg_clk_en && !ram_clk_en && !core_clk_en, "R7 stall all off",
                    32'({core_clk_en, reg_clk_en, ram_clk_en}), 32'h0);
            else
                chk_en(1'b0, "stall resume");
            if (c == W + 4)
                chk(bus_rdata == 32'h100, "R9 read after stall", bus_rdata, 32'h100);
        end
        @(negedge clk);
        bus_req = 1'b0;
        #1;
        chk(!reg_clk_en && !ram_clk_en, "R2 idle off after stall",
            32'({reg_clk_en, ram_clk_en}), 32'h0);
        run_vec('{1'b0, 1'b1, 8'h00, 32'h0000_0000, 32'h0, 1'b0});

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule